// File: doc/BRIEF.md
# Audio Link Output Slot Packer

This block is the controller end of a frame-based serial audio link. Once per 256-bit frame it takes a snapshot of the host-side inputs: an optional register command and a pair of playback samples. From that snapshot it builds the outgoing frame and shifts it out most significant bit first, one bit per bit clock. A frame is a 16-bit tag slot followed by twelve 20-bit slots. The tag slot carries a frame-valid flag and one valid flag per slot. Slot 1 is the command-address slot, slot 2 the command-data slot, slots 3 and 4 the left and right playback slots. Slots 5 to 12 always go out empty.

The block applies all zero stuffing itself. A sample of any width from 1 to 20 bits is left-aligned in its slot with trailing zeros. A mono flag copies the left sample into both playback slots. A store aimed at an odd register index is cancelled rather than sent. Commands arrive on a valid/ready handshake. The handshake opens only in the last bit clock of a frame, and each accepted command goes out in exactly the one frame that follows.

Top module: `aclink_out_packer`

## Requirements
- R1: Each frame is 256 bit clocks long: a 16-bit tag slot, then twelve 20-bit slots, each sent most significant bit first. `syncOut` is high for exactly the 16 bit clocks of the tag slot.
- R2: Tag bit 15 is high when any slot valid bit is set. Tag bits 14 down to 3 are the valid flags of slots 1 to 12, in that order. Tag bits 2:0 are zero.
- R3: The command-address slot (slot 1) holds the direction in bit 19 (1 = read, 0 = write), the 7-bit register index in bits 18:12, and zeros in bits 11:0. Its valid flag is set whenever a command is issued.
- R4: For a write, the command-data slot (slot 2) holds the 16-bit write data in bits 19:4 and zeros in bits 3:0, and its valid flag is set. For a read, the whole slot is zero and its valid flag is clear.
- R5: Each playback sample enters right-aligned in the low `sampleBits` bits of its 20-bit input. In the slot it is left-aligned in bits 19 down to 20-`sampleBits`, and all lower bits are zero. A `sampleBits` of 0 or above 20 counts as 20.
- R6: When `mono` is high, slot 4 carries the same value as slot 3, built from `pcmLeft`.
- R7: A write command with an odd register index (index bit 0 = 1) is accepted but cancelled. Slots 1 and 2 go out as zeros with their valid flags clear. A read with an odd index is issued normally.
- R8: Slots 5 to 12 are always all zero, and their valid flags are clear.
- R9: `cmdReady` is high only in the last bit clock of a frame. A command with `cmdValid` high in that clock is consumed and appears only in the next frame. A frame with no accepted command has slots 1 and 2 zero and their valid flags clear.
- R10: While `rstN` is low, `syncOut`, `sdataOut` and `cmdReady` are low. The first frame starts on the first bit-clock edge after reset is released.
- R11: When `pcmValid` is low, slots 3 and 4 are zero and their valid flags are clear. When it is high, both valid flags are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; outputs change on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A register command is offered |
| cmdReady | output | 1 | Command accepted in this cycle (last bit clock of a frame) |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdIndex | input | 7 | Register index |
| cmdData | input | 16 | Write data |
| pcmValid | input | 1 | Playback samples present in the next frame |
| pcmLeft | input | 20 | Left sample, right-aligned |
| pcmRight | input | 20 | Right sample, right-aligned |
| sampleBits | input | 5 | Sample resolution in bits (1 to 20) |
| mono | input | 1 | Copy left sample into both playback slots |
| syncOut | output | 1 | Frame sync, high during the tag slot |
| sdataOut | output | 1 | Serial frame data |

## Verification
All inputs are captured on the edge that ends a frame, that is, the edge after the cycle where `cmdReady` is high. The first bit of the new frame appears on `sdataOut` in the cycle right after that edge, and bit k of the frame follows k cycles later. The bench waits until it sees `cmdReady` at a falling edge. It then reads the 256 bits of the frame and the sync level at the next 256 falling edges and compares them against a frame built from the requirements. It also checks that `cmdReady` appears only at the last of those edges.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  parameter int SLOT_W    = 20;
  parameter int TAG_W     = 16;
  parameter int NUM_SLOTS = 12;
  parameter int IDX_W     = 7;
  parameter int DATA_W    = 16;
  localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int POS_W    = $clog2(FRAME_W);
  localparam int RES_W    = $clog2(SLOT_W + 1);

  typedef struct packed {
    logic load;   // build and load the next frame
    logic take;   // a command is consumed into that frame
  } strobe_t;

  // Left-align a right-aligned sample of 'bits' width in a slot.
  function automatic logic [SLOT_W-1:0] msbJustify(input logic [SLOT_W-1:0] raw,
                                                   input logic [RES_W-1:0] bits);
    logic [RES_W-1:0] eff;
    eff = (bits == '0 || int'(bits) > SLOT_W) ? RES_W'(SLOT_W) : bits;
    return raw << (RES_W'(SLOT_W) - eff);
  endfunction
endpackage

// File: rtl/aclink_ctrl.sv
module aclink_ctrl
  import aclink_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int TW = TAG_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  output logic    cmdReady,
  output logic    syncOut,
  output strobe_t strb
);
  localparam int PW = $clog2(FW);
  localparam logic [PW-1:0] LAST = PW'(FW - 1);

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rstN) pos <= LAST;
    else       pos <= (pos == LAST) ? '0 : pos + 1'b1;
  end

  assign cmdReady  = rstN && (pos == LAST);
  assign strb.load = cmdReady;
  assign strb.take = cmdReady && cmdValid;

  always_ff @(posedge clk) begin
    if (!rstN) syncOut <= 1'b0;
    else       syncOut <= (pos == LAST) || (pos < PW'(TW - 1));
  end

  // R9
  ready_then_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |=> syncOut);
  // R1
  sync_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncOut && pos == PW'(TW - 1)) |=> !syncOut);
endmodule

// File: rtl/aclink_dp.sv
module aclink_dp
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              cmdRead,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              pcmValid,
  input  logic [SLOT_W-1:0] pcmLeft,
  input  logic [SLOT_W-1:0] pcmRight,
  input  logic [RES_W-1:0]  sampleBits,
  input  logic              mono,
  output logic              sdataOut
);
  localparam int S1_HI = FRAME_W - TAG_W - 1;
  localparam int S2_HI = S1_HI - SLOT_W;
  localparam int S3_HI = S2_HI - SLOT_W;
  localparam int S4_HI = S3_HI - SLOT_W;
  localparam int REST_HI = S4_HI - SLOT_W;

  logic [SLOT_W-1:0]    slotVal [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotValid;
  logic [FRAME_W-1:0]   frameNext;
  logic [FRAME_W-1:0]   shiftReg;
  logic [SLOT_W-1:0]    justL, justR;
  logic                 cmdOk;

  assign justL = msbJustify(pcmLeft, sampleBits);
  assign justR = msbJustify(pcmRight, sampleBits);
  assign cmdOk = strb.take && (cmdRead || !cmdIndex[0]);

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      slotVal[s]   = '0;
      slotValid[s] = 1'b0;
    end
    if (cmdOk) begin
      slotVal[0]   = {cmdRead, cmdIndex, {(SLOT_W-1-IDX_W){1'b0}}};
      slotValid[0] = 1'b1;
      if (!cmdRead) begin
        slotVal[1]   = {cmdData, {(SLOT_W-DATA_W){1'b0}}};
        slotValid[1] = 1'b1;
      end
    end
    if (pcmValid) begin
      slotVal[2]   = justL;
      slotVal[3]   = mono ? justL : justR;
      slotValid[2] = 1'b1;
      slotValid[3] = 1'b1;
    end
  end

  always_comb begin
    frameNext = '0;
    frameNext[FRAME_W-1] = |slotValid;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      frameNext[FRAME_W-2-s] = slotValid[s];
      frameNext[S1_HI - s*SLOT_W -: SLOT_W] = slotVal[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          shiftReg <= '0;
    else if (strb.load) shiftReg <= frameNext;
    else                shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
  end

  assign sdataOut = shiftReg[FRAME_W-1];

  // R7
  odd_store_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && !cmdRead && cmdIndex[0]) |=>
      (shiftReg[FRAME_W-2 -: 2] == 2'b00 && shiftReg[S1_HI -: 2*SLOT_W] == '0));
  // R6
  mono_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && mono) |=> (shiftReg[S3_HI -: SLOT_W] == shiftReg[S4_HI -: SLOT_W]));
  // R4
  read_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && cmdRead) |=> (shiftReg[S2_HI -: SLOT_W] == '0 && !shiftReg[FRAME_W-3]));
  // R8
  spare_slots_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (shiftReg[REST_HI:0] == '0));
endmodule

// File: rtl/aclink_out_packer.sv
module aclink_out_packer
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdRead,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              pcmValid,
  input  logic [SLOT_W-1:0] pcmLeft,
  input  logic [SLOT_W-1:0] pcmRight,
  input  logic [RES_W-1:0]  sampleBits,
  input  logic              mono,
  output logic              syncOut,
  output logic              sdataOut
);
  strobe_t strb;

  aclink_ctrl #(.FW(FRAME_W), .TW(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .syncOut(syncOut), .strb(strb)
  );

  aclink_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cmdRead(cmdRead), .cmdIndex(cmdIndex), .cmdData(cmdData),
    .pcmValid(pcmValid), .pcmLeft(pcmLeft), .pcmRight(pcmRight),
    .sampleBits(sampleBits), .mono(mono), .sdataOut(sdataOut)
  );
endmodule

// File: tb/aclink_out_packer_bench.sv
module aclink_out_packer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdRead = 1'b0, pcmValid = 1'b0, mono = 1'b0;
  logic [6:0]  cmdIndex = '0;
  logic [15:0] cmdData = '0;
  logic [19:0] pcmLeft = '0, pcmRight = '0;
  logic [4:0]  sampleBits = 5'd20;
  logic cmdReady, syncOut, sdataOut;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  aclink_out_packer u_aclink_out_packer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdRead(cmdRead), .cmdIndex(cmdIndex), .cmdData(cmdData),
    .pcmValid(pcmValid), .pcmLeft(pcmLeft), .pcmRight(pcmRight),
    .sampleBits(sampleBits), .mono(mono), .syncOut(syncOut), .sdataOut(sdataOut)
  );

  typedef struct packed {
    logic cv; logic rd; logic [6:0] idx; logic [15:0] dat;
    logic pv; logic [19:0] l; logic [19:0] r; logic [4:0] bits; logic mo;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 7'h02, 16'hA5C3, 1'b1, 20'h000AB, 20'h00012, 5'd8,  1'b0}, // R3 R4 R5
    '{1'b0, 1'b0, 7'h00, 16'h0000, 1'b1, 20'hFEDCB, 20'h12345, 5'd20, 1'b0}, // R9 R5
    '{1'b1, 1'b1, 7'h7E, 16'hFFFF, 1'b1, 20'h0003C, 20'h0001F, 5'd6,  1'b1}, // R4 R6
    '{1'b1, 1'b0, 7'h13, 16'h1234, 1'b0, 20'h00001, 20'h00002, 5'd20, 1'b0}, // R7 R11
    '{1'b1, 1'b1, 7'h05, 16'h0000, 1'b0, 20'h00000, 20'h00000, 5'd20, 1'b0}, // R7 odd read
    '{1'b0, 1'b0, 7'h00, 16'h0000, 1'b1, 20'h00001, 20'h00000, 5'd1,  1'b0}, // R5 one bit
    '{1'b0, 1'b0, 7'h00, 16'h0000, 1'b1, 20'h8F00F, 20'h00F0F, 5'd0,  1'b0}, // R5 zero -> 20
    '{1'b1, 1'b0, 7'h40, 16'h0001, 1'b1, 20'hABCDE, 20'h13579, 5'd25, 1'b1}, // R5 over -> 20, R6
    '{1'b0, 1'b0, 7'h00, 16'h0000, 1'b0, 20'h00000, 20'h00000, 5'd20, 1'b0}  // R2 empty frame
  };

  function automatic logic [19:0] leftAlign(input logic [19:0] x, input logic [4:0] b);
    int w;
    logic [19:0] o;
    w = (b == 0 || b > 20) ? 20 : int'(b);
    o = '0;
    for (int k = 0; k < w; k++) o[19-k] = x[w-1-k];
    return o;
  endfunction

  function automatic logic [255:0] expectFrame(input vec_t v);
    logic ok;
    logic [19:0] s1, s2, s3, s4;
    logic [15:0] tag;
    ok = v.cv && (v.rd || !v.idx[0]);
    s1 = ok ? {v.rd, v.idx, 12'h000} : 20'h0;
    s2 = (ok && !v.rd) ? {v.dat, 4'h0} : 20'h0;
    s3 = v.pv ? leftAlign(v.l, v.bits) : 20'h0;
    s4 = v.pv ? leftAlign(v.mo ? v.l : v.r, v.bits) : 20'h0;
    tag = '0;
    tag[14] = ok;
    tag[13] = ok && !v.rd;
    tag[12] = v.pv;
    tag[11] = v.pv;
    tag[15] = |tag[14:3];
    return {tag, s1, s2, s3, s4, 160'h0};
  endfunction

  task automatic check(input bit good, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runFrame(input vec_t v, input string req);
    logic [255:0] got, want;
    logic [255:0] syn, synWant;
    logic [255:0] rdy, rdyWant;
    cmdValid = v.cv; cmdRead = v.rd; cmdIndex = v.idx; cmdData = v.dat;
    pcmValid = v.pv; pcmLeft = v.l; pcmRight = v.r; sampleBits = v.bits; mono = v.mo;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (i == 0) cmdValid = 1'b0;
      got[255-i] = sdataOut;
      syn[255-i] = syncOut;
      rdy[255-i] = cmdReady;
    end
    want    = expectFrame(v);
    synWant = {16'hFFFF, 240'h0};
    rdyWant = 256'h1;
    check(got == want, {req, " frame content"}, got, want);
    check(syn == synWant, "R1 sync window", syn, synWant);
    check(rdy == rdyWant, "R9 ready only at frame end", rdy, rdyWant);
  endtask

  initial begin
    // R10: outputs quiet during reset
    repeat (3) @(negedge clk);
    check(syncOut == 1'b0, "R10 sync in reset", 256'(syncOut), 256'h0);
    check(sdataOut == 1'b0, "R10 data in reset", 256'(sdataOut), 256'h0);
    check(cmdReady == 1'b0, "R10 ready in reset", 256'(cmdReady), 256'h0);
    rstN = 1'b1;
    #0;
    check(cmdReady == 1'b1, "R10 ready right after release", 256'(cmdReady), 256'h1);
    @(negedge clk);
    check(syncOut == 1'b1, "R10 first frame starts", 256'(syncOut), 256'h1);
    for (int n = 0; n < NV; n++) runFrame(VECS[n], $sformatf("R2 R3 R8 vec%0d", n));
    // R9: command held valid is consumed once; the following frame is empty of it
    runFrame(VECS[0], "R9 first carrier");
    runFrame(VECS[1], "R9 consumed once");
    // R7: odd write then even write back to back
    runFrame(VECS[3], "R7 odd write cancelled");
    runFrame(VECS[0], "R7 even write after odd");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule